// File: doc/BRIEF.md
# Sync-Gated Ramp Pattern Generator with Loopback Checker

This block feeds the 8-bit parallel transmit word of a serial transceiver lane during link bring-up. As long as the receive side has not reported word alignment, it repeats the alignment comma 0xBC and raises a control flag, so the far end can find its word boundary. Once alignment is reported, it sends a repeating ramp 0, 1, …, 14, 0, … with the flag low.

The sync status arrives from another clock domain. It passes through a two-stage synchronizer before the transmit state machine uses it. The transmit state machine has two states. `ST_ALIGN` sends the comma and moves to `ST_RAMP` when the synchronized status is high. `ST_RAMP` sends the counter and moves back to `ST_ALIGN` when the status goes low.

A receive-side checker lets the lane be tested in loopback. Its state machine starts in `ST_HUNT` and moves to `ST_TRACK` on the first unflagged word. It stays in `ST_TRACK` until reset. In `ST_TRACK` it compares each unflagged word with the successor of the previous one and counts mismatches. The whole block runs on the transmit clock, nominally 100 MHz.

Top module: `lpg_loop_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tx_data` is 0xBC, `tx_is_ctrl` is 1, `err_count` is 0 and `rx_locked` is 0. Reset also clears the synchronizer stages.
- R2: While the synchronized status is low, `tx_data` is 0xBC and `tx_is_ctrl` is 1.
- R3: A change on `sync_in` reaches `tx_data`/`tx_is_ctrl` after the third rising clock edge. That is two synchronizer stages plus the state register.
- R4: The first payload word after each rise of the status is 0. Each later payload word is (previous + 1) modulo 15, so it wraps from 14 to 0. Payload words have bits 7:4 at zero and `tx_is_ctrl` at 0.
- R5: When the synchronized status drops during payload, the next word is 0xBC. The counter restarts at 0 on the next rise.
- R6: The checker ignores words with `rx_is_ctrl` = 1. They change neither `err_count` nor `rx_locked`.
- R7: The checker sets `rx_locked` on the clock edge that takes the first unflagged word after reset. It keeps `rx_locked` set until reset.
- R8: When locked, an unflagged word that differs from (previous word + 1) modulo 15 adds one to `err_count`. The modulo is taken on the full 8-bit previous value. The received word becomes the new reference in every case.
- R9: `err_count` is 16 bits wide and saturates at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Receiver word-alignment status, asynchronous |
| tx_data | output | 8 | Parallel transmit word |
| tx_is_ctrl | output | 1 | High when `tx_data` carries the comma |
| rx_data | input | 8 | Parallel receive word for the checker |
| rx_is_ctrl | input | 1 | High when `rx_data` is a control character |
| rx_locked | output | 1 | Checker has locked onto the ramp |
| err_count | output | 16 | Saturating count of ramp mismatches |

## Verification
The bound assertions check several rules on every cycle: that the flag and the data agree, that payload words run on modulo 15 and start at 0, that the output follows the status three edges later, that flagged receive words leave the checker untouched, and that the error count rises by at most one per cycle and never falls. Only the bench scenarios can show the rest. These are the exact error totals after a ramp restarts in the middle of tracking, re-lock on an out-of-range word, saturation after more than 65535 mismatches, and a reset in the middle of payload that clears the synchronizer.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    typedef enum logic {ST_ALIGN = 1'b0, ST_RAMP = 1'b1} tx_state_t;
    typedef enum logic {ST_HUNT = 1'b0, ST_TRACK = 1'b1} rx_state_t;
endpackage

// File: rtl/lpg_sync.sv
module lpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpg_tx.sv
module lpg_tx
    import lpg_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] CTRL_CHAR = 8'hBC,
    parameter int              RAMP_MOD  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              synced,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_is_ctrl
);
    localparam int CNT_W = (RAMP_MOD > 1) ? $clog2(RAMP_MOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RAMP_MOD - 1);

    tx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ALIGN;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ALIGN: if (synced)  state_d = ST_RAMP;
            ST_RAMP:  if (!synced) state_d = ST_ALIGN;
        endcase
    end

    // ramp counter: held at zero outside payload
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (state_q == ST_RAMP && synced)
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ALIGN: begin
                tx_data    = CTRL_CHAR;
                tx_is_ctrl = 1'b1;
            end
            ST_RAMP: begin
                tx_data    = DATA_W'(cnt_q);
                tx_is_ctrl = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lpg_rx_check.sv
module lpg_rx_check
    import lpg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RAMP_MOD = 15,
    parameter int ERR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_ctrl,
    output logic              rx_locked,
    output logic [ERR_W-1:0]  err_count
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    rx_state_t         state_q, state_d;
    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] expect_w;
    logic              mismatch;

    function automatic logic [DATA_W-1:0] succ(input logic [DATA_W-1:0] v);
        logic [DATA_W:0] wide;
        wide = ({1'b0, v} + 1'b1) % (DATA_W+1)'(RAMP_MOD);
        return wide[DATA_W-1:0];
    endfunction

    assign expect_w = succ(ref_q);
    assign mismatch = (state_q == ST_TRACK) && !rx_is_ctrl && (rx_data != expect_w);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (!rx_is_ctrl) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q     <= '0;
            err_count <= '0;
        end else begin
            if (!rx_is_ctrl) ref_q <= rx_data;
            if (mismatch && err_count != ERR_MAX) err_count <= err_count + 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HUNT:  rx_locked = 1'b0;
            ST_TRACK: rx_locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/lpg_loop_top.sv
module lpg_loop_top #(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] CTRL_CHAR   = 8'hBC,
    parameter int                RAMP_MOD    = 15,
    parameter int                ERR_W       = 16,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_is_ctrl,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_ctrl,
    output logic              rx_locked,
    output logic [ERR_W-1:0]  err_count
);
    logic synced;

    lpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sync_in),
        .q_sync  (synced)
    );

    lpg_tx #(.DATA_W(DATA_W), .CTRL_CHAR(CTRL_CHAR), .RAMP_MOD(RAMP_MOD)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .synced     (synced),
        .tx_data    (tx_data),
        .tx_is_ctrl (tx_is_ctrl)
    );

    lpg_rx_check #(.DATA_W(DATA_W), .RAMP_MOD(RAMP_MOD), .ERR_W(ERR_W)) u_chk (
        .clk        (clk),
        .rst        (rst),
        .rx_data    (rx_data),
        .rx_is_ctrl (rx_is_ctrl),
        .rx_locked  (rx_locked),
        .err_count  (err_count)
    );
endmodule

// File: rtl/lpg_loop_sva.sv
module lpg_loop_sva #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] CTRL_CHAR = 8'hBC,
    parameter int                RAMP_MOD  = 15,
    parameter int                ERR_W     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_is_ctrl,
    input logic              rx_is_ctrl,
    input logic              rx_locked,
    input logic [ERR_W-1:0]  err_count
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (tx_is_ctrl && tx_data == CTRL_CHAR && err_count == '0 && !rx_locked));

    assert_flag_means_comma_R2: assert property (@(posedge clk) disable iff (rst)
        tx_is_ctrl |-> tx_data == CTRL_CHAR);

    assert_sync_latency_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(sync_in, 3) |-> tx_is_ctrl);

    assert_payload_range_R4: assert property (@(posedge clk) disable iff (rst)
        !tx_is_ctrl |-> (int'(tx_data) < RAMP_MOD));

    assert_ramp_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!tx_is_ctrl && !$past(tx_is_ctrl)) |->
            (int'(tx_data) == (int'($past(tx_data)) + 1) % RAMP_MOD));

    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_is_ctrl) |-> tx_data == '0);

    assert_ctrl_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        rx_is_ctrl |=> ($stable(err_count) && $stable(rx_locked)));

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        rx_locked |=> rx_locked);

    assert_err_step_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_count >= $past(err_count) && err_count - $past(err_count) <= 1));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (&err_count) |=> (&err_count));
endmodule

bind lpg_loop_top lpg_loop_sva #(
    .DATA_W(DATA_W), .CTRL_CHAR(CTRL_CHAR), .RAMP_MOD(RAMP_MOD), .ERR_W(ERR_W)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .sync_in    (sync_in),
    .tx_data    (tx_data),
    .tx_is_ctrl (tx_is_ctrl),
    .rx_is_ctrl (rx_is_ctrl),
    .rx_locked  (rx_locked),
    .err_count  (err_count)
);

// File: tb/lpg_loop_top_test.sv
module lpg_loop_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_in = 1'b0;
    logic        inject = 1'b0;
    logic [7:0]  inj_data = 8'h00;
    logic        inj_ctrl = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_is_ctrl;
    logic [7:0]  rx_data;
    logic        rx_is_ctrl;
    logic        rx_locked;
    logic [15:0] err_count;
    int          n_checks = 0;
    int          n_fail   = 0;
    int          exp_v;

    always #4 clk = ~clk;

    assign rx_data    = inject ? inj_data : tx_data;
    assign rx_is_ctrl = inject ? inj_ctrl : tx_is_ctrl;

    lpg_loop_top uut (
        .clk(clk), .rst(rst), .sync_in(sync_in),
        .tx_data(tx_data), .tx_is_ctrl(tx_is_ctrl),
        .rx_data(rx_data), .rx_is_ctrl(rx_is_ctrl),
        .rx_locked(rx_locked), .err_count(err_count)
    );

    // {sync_in, expected tx_data}; flag expected high exactly when data is 0xBC
    localparam logic [8:0] VEC [12] = '{
        {1'b0, 8'hBC}, {1'b1, 8'hBC}, {1'b1, 8'hBC}, {1'b1, 8'h00},
        {1'b1, 8'h01}, {1'b1, 8'h02}, {1'b0, 8'h03}, {1'b0, 8'h04},
        {1'b1, 8'hBC}, {1'b1, 8'hBC}, {1'b1, 8'h00}, {1'b1, 8'h01}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, one rising edge, sample at the following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset state
        chk("R1 tx_data", tx_data, 8'hBC);
        chk("R1 flag", tx_is_ctrl, 1);
        chk("R1 err", err_count, 0);
        chk("R1 locked", rx_locked, 0);
        rst = 1'b0;

        // R2 R3 R4 R5: table walk in loopback
        for (int i = 0; i < 12; i++) begin
            sync_in = VEC[i][8];
            step();
            chk("R2/R3/R4/R5 table data", tx_data, VEC[i][7:0]);
            chk("R2/R4 table flag", tx_is_ctrl, (VEC[i][7:0] == 8'hBC) ? 1 : 0);
        end
        // ramp 0..4 then restart at 0 while tracking: one mismatch (R8)
        chk("R8 loopback restart err", err_count, 1);
        chk("R7 loopback locked", rx_locked, 1);

        // R4 long run with wrap 14 -> 0
        exp_v = 1;
        for (int i = 0; i < 30; i++) begin
            step();
            exp_v = (exp_v + 1) % 15;
            chk("R4 wrap data", tx_data, exp_v);
            chk("R4 wrap flag", tx_is_ctrl, 0);
        end
        chk("R8 wrap no error", err_count, 1);

        // R3 R5 drop of sync: two more ramp words, then comma
        sync_in = 1'b0;
        step();
        exp_v = (exp_v + 1) % 15;
        chk("R3 drop latency 1", tx_data, exp_v);
        step();
        exp_v = (exp_v + 1) % 15;
        chk("R3 drop latency 2", tx_data, exp_v);
        step();
        chk("R5 drop comma", tx_data, 8'hBC);
        chk("R5 drop flag", tx_is_ctrl, 1);
        step();
        chk("R6 comma in loopback ignored", err_count, 1);

        // R1 reset in the middle of payload clears synchronizer
        sync_in = 1'b1;
        for (int i = 0; i < 5; i++) step();
        chk("R4 payload before reset", tx_is_ctrl, 0);
        rst = 1'b1;
        step();
        chk("R1 mid reset data", tx_data, 8'hBC);
        chk("R1 mid reset err", err_count, 0);
        chk("R1 mid reset locked", rx_locked, 0);
        step();
        rst = 1'b0;
        step();
        chk("R1 sync cleared 0", tx_is_ctrl, 1);
        step();
        chk("R1 sync cleared 1", tx_is_ctrl, 1);
        step();
        chk("R4 first word after reset", tx_data, 0);

        // checker with injected words
        rst = 1'b1;
        sync_in = 1'b0;
        inject = 1'b1;
        step();
        rst = 1'b0;
        inj_ctrl = 1'b1; inj_data = 8'h55; step();
        chk("R6 ctrl before lock", rx_locked, 0);
        chk("R6 ctrl err", err_count, 0);
        inj_ctrl = 1'b0; inj_data = 8'd7; step();
        chk("R7 lock on first word", rx_locked, 1);
        chk("R7 no error on lock", err_count, 0);
        inj_data = 8'd8; step();
        inj_data = 8'd9; step();
        chk("R8 in-order words", err_count, 0);
        inj_data = 8'd3; step();
        chk("R8 mismatch counted", err_count, 1);
        inj_data = 8'd4; step();
        chk("R8 relock on mismatch", err_count, 1);
        inj_ctrl = 1'b1; inj_data = 8'h00; step();
        chk("R6 ctrl while locked", err_count, 1);
        inj_ctrl = 1'b0; inj_data = 8'd5; step();
        chk("R6 ref kept across ctrl", err_count, 1);
        inj_data = 8'h20; step();
        chk("R8 out-of-range word", err_count, 2);
        inj_data = 8'd3; step();
        chk("R8 modulo of 0x20", err_count, 2);
        inj_data = 8'd14; step();
        inj_data = 8'd0; step();
        chk("R8 wrap accepted", err_count, 3);

        // R9 saturation: 0 after 0 always mismatches
        rst = 1'b1;
        step();
        rst = 1'b0;
        inj_data = 8'd0;
        for (int i = 0; i < 65540; i++) step();
        chk("R9 saturated", err_count, 65535);
        step();
        chk("R9 held", err_count, 65535);

        finish_run();
    end
endmodule